// File: doc/BRIEF.md
# Memory Fill Engine

This block writes one 64-bit pattern over a contiguous span of memory, for example to give every ECC word in DRAM a known value after training. Software first programs a destination byte pointer, a byte count and the two 32-bit halves of the pattern on plain configuration inputs. It then pulses a start input. While the fill runs, the engine drives full-width write beats on a valid/ready write port and keeps its active status high. After the final beat it pulses `done` for one cycle and then drops back to idle. Software finds out that the fill has finished by polling the status until it reads idle.

The write port follows the usual rules for back-pressure. A beat moves on a rising edge where `wr_valid` and `wr_ready` are both high. While `wr_valid` is high and `wr_ready` is low, the address, data and strobes hold still. The engine never takes `wr_valid` back before the beat is accepted. Every beat covers one aligned word, and the address rises by the word size in bytes after each accepted beat. The strobes of the first and last words cut away any bytes that lie outside the span, so a pointer or byte count that is not word-aligned is handled. The count register cannot hold the full size of the address space, so the all-ones value stands for the whole space. A start is accepted only when the engine is idle and the count is within the allowed range.

Top module: `memfill_engine`

## Requirements
- R1: After reset, `status_active`, `wr_valid` and `done` are all low.
- R2: An accepted start takes effect on the rising edge that samples it. From the next cycle `status_active` and `wr_valid` are high. The first beat's address is `cfg_dst_ptr` with its low 3 bits cleared.
- R3: A `cfg_size` of all ones requests a fill of 2^ADDR_W bytes, the whole address space, and it is always accepted. The address wraps modulo 2^ADDR_W.
- R4: A start with `cfg_size` zero, below MIN_SIZE or above MAX_SIZE (other than all ones) is refused: no beat is issued and `status_active` stays low.
- R5: A start pulse is ignored while `status_active` is high, including the cycle in which `done` is high.
- R6: Each accepted beat advances the address by 8 bytes. `wr_data` is `{cfg_pat_hi, cfg_pat_lo}`, and byte lane i (`wr_data[8i+7:8i]`, strobe bit i) is written to address `wr_addr + i`.
- R7: Over one fill, every byte address in [ptr, ptr + count) modulo 2^ADDR_W is strobed exactly once, and no other byte is strobed. Every strobed beat has at least one strobe bit set.
- R8: While `wr_valid` is high and `wr_ready` is low, the next cycle still has `wr_valid` high with `wr_addr`, `wr_data` and `wr_strb` unchanged.
- R9: `done` is high for exactly the one cycle after the last beat is accepted, with `status_active` still high. In the following cycle `status_active` is low.
- R10: The pointer, size and pattern are captured at an accepted start. Changes to the configuration inputs during a fill have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dst_ptr | input | ADDR_W | Destination byte pointer |
| cfg_size | input | ADDR_W | Byte count; all ones means the whole address space |
| cfg_pat_hi | input | PAT_W | Upper half of the fill pattern |
| cfg_pat_lo | input | PAT_W | Lower half of the fill pattern |
| cfg_start | input | 1 | Start request pulse |
| wr_addr | output | ADDR_W | Word-aligned byte address of the current beat |
| wr_data | output | 2*PAT_W | Beat data |
| wr_strb | output | 2*PAT_W/8 | Byte strobes, bit i for lane i |
| wr_valid | output | 1 | Beat present |
| wr_ready | input | 1 | Sink accepts the beat |
| status_active | output | 1 | High from an accepted start through the done cycle |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
On every cycle, the assertions check that beats stay stable under back-pressure and that the address steps by one word between accepted beats. They also check that every beat strobes at least one byte, that `done` directly follows an accepted beat and is followed by idle, and that a start with an out-of-range count never raises the status. Some properties cover the whole fill and only the bench scenarios can show them. These are: every byte of the span written exactly once with the right pattern lane and nothing outside it written, the all-ones count covering the whole space across the address wrap, and captured configuration surviving input changes and a start issued during a running or done fill.

// File: rtl/memfill_pkg.sv
package memfill_pkg;

  typedef enum logic [1:0] {
    FILL_IDLE = 2'd0,
    FILL_RUN  = 2'd1,
    FILL_DONE = 2'd2
  } fill_state_e;

endpackage

// File: rtl/memfill_admit.sv
// Decides whether a programmed count may start a fill and converts it to
// a byte count one bit wider, so that the whole space can be represented.
module memfill_admit #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] MIN_SIZE = 8,
  parameter logic [ADDR_W-1:0] MAX_SIZE = '1
) (
  input  logic [ADDR_W-1:0] size_code,
  output logic              size_ok,
  output logic [ADDR_W:0]   byte_count
);

  logic whole_space;
  logic in_window;

  always_comb begin
    whole_space = &size_code;
    in_window   = (size_code != '0) && (size_code >= MIN_SIZE) &&
                  (size_code <= MAX_SIZE);
    size_ok     = whole_space || in_window;
    if (whole_space) begin
      byte_count = {1'b1, {ADDR_W{1'b0}}};
    end else begin
      byte_count = {1'b0, size_code};
    end
  end

endmodule

// File: rtl/memfill_walker.sv
// Walks word-aligned addresses across the span and forms the byte strobes.
// rem_q counts bytes from the current word base to the end of the span.
module memfill_walker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STRB_W = 8,
  parameter int unsigned OFS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W:0]   byte_count,
  input  logic              advance,
  output logic [ADDR_W-1:0] word_addr,
  output logic [STRB_W-1:0] strb,
  output logic              last_word
);

  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(STRB_W);
  localparam logic [ADDR_W:0]   REM_STEP  = (ADDR_W+1)'(STRB_W);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W:0]   rem_q;
  logic [OFS_W-1:0]  lead_q;
  logic [ADDR_W:0]   lead_ext;

  assign lead_ext = {{(ADDR_W+1-OFS_W){1'b0}}, ptr[OFS_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      lead_q <= '0;
    end else if (load) begin
      addr_q <= {ptr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
      rem_q  <= byte_count + lead_ext;
      lead_q <= ptr[OFS_W-1:0];
    end else if (advance) begin
      addr_q <= addr_q + ADDR_STEP;
      rem_q  <= rem_q - REM_STEP;
      lead_q <= '0;
    end
  end

  assign word_addr = addr_q;
  assign last_word = (rem_q <= REM_STEP);

  for (genvar i = 0; i < STRB_W; i++) begin : g_lane
    assign strb[i] = (OFS_W'(i) >= lead_q) && ((ADDR_W+1)'(i) < rem_q);
  end

endmodule

// File: rtl/memfill_seq.sv
// Run-state sequencer: idle, running, one-cycle done.
module memfill_seq
  import memfill_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        size_ok,
  input  logic        beat_fire,
  input  logic        last_word,
  output logic        load,
  output fill_state_e state
);

  fill_state_e state_q;
  fill_state_e state_d;

  assign load = start && size_ok && (state_q == FILL_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      FILL_IDLE: if (load) state_d = FILL_RUN;
      FILL_RUN:  if (beat_fire && last_word) state_d = FILL_DONE;
      FILL_DONE: state_d = FILL_IDLE;
      default:   state_d = FILL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= FILL_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/memfill_engine.sv
module memfill_engine
  import memfill_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAT_W  = 32,
  parameter logic [ADDR_W-1:0] MIN_SIZE = 8,
  parameter logic [ADDR_W-1:0] MAX_SIZE = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cfg_dst_ptr,
  input  logic [ADDR_W-1:0]    cfg_size,
  input  logic [PAT_W-1:0]     cfg_pat_hi,
  input  logic [PAT_W-1:0]     cfg_pat_lo,
  input  logic                 cfg_start,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [2*PAT_W-1:0]   wr_data,
  output logic [2*PAT_W/8-1:0] wr_strb,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic                 status_active,
  output logic                 done
);

  localparam int unsigned DATA_W = 2 * PAT_W;
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned OFS_W  = $clog2(STRB_W);

  logic              size_ok;
  logic [ADDR_W:0]   byte_count;
  logic              load;
  logic              beat_fire;
  logic              last_word;
  fill_state_e       state;
  logic [DATA_W-1:0] pat_q;

  memfill_admit #(
    .ADDR_W  (ADDR_W),
    .MIN_SIZE(MIN_SIZE),
    .MAX_SIZE(MAX_SIZE)
  ) u_admit (
    .size_code (cfg_size),
    .size_ok   (size_ok),
    .byte_count(byte_count)
  );

  memfill_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cfg_start),
    .size_ok  (size_ok),
    .beat_fire(beat_fire),
    .last_word(last_word),
    .load     (load),
    .state    (state)
  );

  memfill_walker #(
    .ADDR_W(ADDR_W),
    .STRB_W(STRB_W),
    .OFS_W (OFS_W)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ptr       (cfg_dst_ptr),
    .byte_count(byte_count),
    .advance   (beat_fire),
    .word_addr (wr_addr),
    .strb      (wr_strb),
    .last_word (last_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    pat_q <= '0;
    else if (load) pat_q <= {cfg_pat_hi, cfg_pat_lo};
  end

  assign wr_valid      = (state == FILL_RUN);
  assign beat_fire     = wr_valid && wr_ready;
  assign wr_data       = pat_q;
  assign status_active = (state != FILL_IDLE);
  assign done          = (state == FILL_DONE);

endmodule

// File: rtl/memfill_checker.sv
module memfill_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAT_W  = 32,
  parameter logic [ADDR_W-1:0] MIN_SIZE = 8,
  parameter logic [ADDR_W-1:0] MAX_SIZE = '1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    cfg_size,
  input logic                 cfg_start,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [2*PAT_W-1:0]   wr_data,
  input logic [2*PAT_W/8-1:0] wr_strb,
  input logic                 wr_valid,
  input logic                 wr_ready,
  input logic                 status_active,
  input logic                 done
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2 * PAT_W / 8);

  logic bad_size;
  assign bad_size = !(&cfg_size) &&
                    ((cfg_size == '0) || (cfg_size < MIN_SIZE) || (cfg_size > MAX_SIZE));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb)));

  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (done || (wr_valid && (wr_addr == $past(wr_addr) + STEP))));

  a_r7_strobe_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_strb != '0));

  a_r2_valid_in_active: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (status_active && !done));

  a_r9_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status_active && $past(wr_valid && wr_ready)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !status_active));

  a_r4_refuse_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_start && !status_active && bad_size) |=> !status_active);

endmodule

bind memfill_engine memfill_checker #(
  .ADDR_W  (ADDR_W),
  .PAT_W   (PAT_W),
  .MIN_SIZE(MIN_SIZE),
  .MAX_SIZE(MAX_SIZE)
) u_memfill_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_size     (cfg_size),
  .cfg_start    (cfg_start),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .wr_strb      (wr_strb),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .status_active(status_active),
  .done         (done)
);

// File: tb/test_memfill_engine.sv
`timescale 1ns/1ps
module test_memfill_engine;

  localparam int AW    = 12;
  localparam int SPACE = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_dst_ptr = '0;
  logic [AW-1:0] cfg_size = '0;
  logic [31:0]   cfg_pat_hi = '0;
  logic [31:0]   cfg_pat_lo = '0;
  logic          cfg_start = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [63:0]   wr_data;
  logic [7:0]    wr_strb;
  logic          wr_valid;
  logic          wr_ready = 1'b0;
  logic          status_active;
  logic          done;

  memfill_engine #(
    .ADDR_W(AW), .PAT_W(32), .MIN_SIZE(12'd4), .MAX_SIZE(12'd256)
  ) i_memfill_engine (
    .clk(clk), .rst_n(rst_n), .cfg_dst_ptr(cfg_dst_ptr), .cfg_size(cfg_size),
    .cfg_pat_hi(cfg_pat_hi), .cfg_pat_lo(cfg_pat_lo), .cfg_start(cfg_start),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .status_active(status_active), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  int mem_cnt [SPACE];
  logic [7:0] mem_val [SPACE];
  int exp_addr = 0;
  int beats_seen = 0;
  logic [63:0] cur_pat = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    case (ready_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = cyc[0];
      2: wr_ready = lfsr[3];
      default: wr_ready = (cyc % 3 == 0);
    endcase
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      chk(1'b0, "WDOG", "watchdog expired", cyc, 150000);
      summary();
    end
  end

  // Monitor, sampling at the falling edge
  logic        prev_stall = 1'b0;
  logic        prev_acc = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [63:0] prev_data;
  logic [7:0]  prev_strb;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(wr_valid && wr_addr == prev_addr && wr_data == prev_data && wr_strb == prev_strb,
            "R8", "beat changed while stalled", {wr_addr, wr_strb}, {prev_addr, prev_strb});
      if (done)
        chk(prev_acc && status_active, "R9", "done without prior beat or inactive",
            {prev_acc, status_active}, 2'b11);
      if (wr_valid && wr_ready) begin
        chk(wr_addr == AW'(exp_addr), "R6", "beat address", wr_addr, exp_addr);
        chk(wr_data == cur_pat, "R6", "beat data", wr_data, cur_pat);
        exp_addr = (exp_addr + 8) % SPACE;
        beats_seen++;
        for (int i = 0; i < 8; i++) begin
          if (wr_strb[i]) begin
            int a;
            a = (int'(wr_addr) + i) % SPACE;
            mem_cnt[a]++;
            mem_val[a] = wr_data[8*i +: 8];
          end
        end
      end
      prev_stall = wr_valid && !wr_ready;
      prev_acc   = wr_valid && wr_ready;
      prev_addr  = wr_addr;
      prev_data  = wr_data;
      prev_strb  = wr_strb;
    end
  end

  task automatic clear_mem();
    for (int a = 0; a < SPACE; a++) begin
      mem_cnt[a] = 0;
      mem_val[a] = 8'h00;
    end
  endtask

  task automatic begin_fill(input int ptr, input int size, input logic [63:0] pat, input int rmode);
    clear_mem();
    ready_mode = rmode;
    @(posedge clk); #2;
    cfg_dst_ptr = AW'(ptr);
    cfg_size    = AW'(size);
    cfg_pat_hi  = pat[63:32];
    cfg_pat_lo  = pat[31:0];
    cfg_start   = 1'b1;
    cur_pat     = pat;
    exp_addr    = ptr & ~7;
    beats_seen  = 0;
    @(posedge clk); #2;
    cfg_start = 1'b0;
    @(negedge clk);
    chk(wr_valid && status_active, "R2", "not running after start",
        {wr_valid, status_active}, 2'b11);
  endtask

  task automatic wait_done(input int nbeats);
    int t;
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done, "R9", "done never seen", t, 0);
    chk(beats_seen == nbeats, "R9", "beats before done", beats_seen, nbeats);
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(!status_active && !done && !wr_valid, "R9", "not idle after done",
        {status_active, done, wr_valid}, 3'b000);
  endtask

  task automatic verify_mem(input int ptr, input int count, input logic [63:0] pat, input string req);
    int bad;
    int bad_a;
    bad = 0;
    bad_a = 0;
    for (int a = 0; a < SPACE; a++) begin
      int k;
      k = (a - ptr + SPACE) % SPACE;
      if (k < count) begin
        if (mem_cnt[a] != 1 || mem_val[a] != pat[8*(a%8) +: 8]) begin
          if (bad == 0) bad_a = a;
          bad++;
        end
      end else if (mem_cnt[a] != 0) begin
        if (bad == 0) bad_a = a;
        bad++;
      end
    end
    chk(bad == 0, req, "bytes wrong, first bad address", bad_a, -1);
  endtask

  task automatic full_fill(input int ptr, input int size, input logic [63:0] pat, input int rmode);
    int count;
    int nbeats;
    count  = (size == SPACE - 1) ? SPACE : size;
    nbeats = ((ptr % 8) + count + 7) / 8;
    begin_fill(ptr, size, pat, rmode);
    wait_done(nbeats);
    after_done();
    verify_mem(ptr, count, pat, (size == SPACE - 1) ? "R3" : "R7");
  endtask

  task automatic refused(input int size, input string what);
    clear_mem();
    @(posedge clk); #2;
    cfg_dst_ptr = 12'h040;
    cfg_size    = AW'(size);
    cfg_start   = 1'b1;
    @(posedge clk); #2;
    cfg_start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!status_active && !wr_valid, "R4", what, {status_active, wr_valid}, 2'b00);
    end
    verify_mem(0, 0, 64'd0, "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!status_active && !wr_valid && !done, "R1", "outputs during reset",
        {status_active, wr_valid, done}, 3'b000);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!status_active && !wr_valid && !done, "R1", "outputs after reset",
        {status_active, wr_valid, done}, 3'b000);

    // R7 / R6 sweep: every lead offset against short counts, varied back-pressure
    for (int off = 0; off < 8; off++) begin
      for (int sz = 4; sz <= 20; sz++) begin
        full_fill(12'h200 + off, sz, {32'hDEADBEEF, 32'hDEADBEEF ^ (off * 97 + sz)}, (off + sz) % 4);
      end
    end

    // R4 bounds: exactly MIN and MAX accepted, outside refused
    full_fill(12'h7F3, 256, 64'h0123_4567_89AB_CDEF, 2);
    full_fill(12'h005, 4, 64'hFEDC_BA98_7654_3210, 1);
    refused(3, "below minimum started");
    refused(257, "above maximum started");
    refused(0, "zero count started");
    refused(12'hFFE, "largest non-full count started");

    // R3: all-ones count covers whole space, aligned and with lead offset
    full_fill(0, SPACE - 1, 64'hDEADBEEF_DEADBEEF, 0);
    full_fill(5, SPACE - 1, 64'hA5A5_5A5A_C3C3_3C3C, 2);

    // R5 and R10: start pulses and config changes while running and at done
    begin_fill(12'h100, 64, 64'h1111_2222_3333_4444, 3);
    repeat (3) @(negedge clk);
    cfg_dst_ptr = 12'h300;
    cfg_size    = 12'd32;
    cfg_pat_hi  = 32'h9999_9999;
    cfg_pat_lo  = 32'h8888_8888;
    @(posedge clk); #2;
    cfg_start = 1'b1;
    @(posedge clk); #2;
    cfg_start = 1'b0;
    wait_done(8);
    cfg_start = 1'b1;
    @(posedge clk); #2;
    cfg_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!status_active && !wr_valid, "R5", "start in done cycle took effect",
          {status_active, wr_valid}, 2'b00);
    end
    verify_mem(12'h100, 64, 64'h1111_2222_3333_4444, "R10");

    // Back-to-back fill after that, to show the engine is still usable
    full_fill(12'hFFC, 9, 64'h0F0F_F0F0_00FF_FF00, 0);

    summary();
  end

endmodule